// File: doc/BRIEF.md
# Indirect-Address SPI Flash Bridge

This block lets a host that only issues byte-wide I/O accesses run SPI flash transactions. The host sees a small register window: four address bytes that together form a 32-bit target address, and one data port. Each data-port access is turned into a memory cycle at the assembled address. When that address falls inside a 4 KB window at the very top of the 32-bit space, bits 15:8 of the address pick what the cycle does to the SPI bus.

One page of the window releases chip select. A second page drops chip select and moves one byte across the SPI lines. A write sends the host byte. A read clocks in one byte from the flash and hands it back to the host. A flash command is therefore issued as follows. The host writes the release page address once. It then rewrites only address byte 1 to select the transfer page. It writes the opcode and operand bytes, reads the reply bytes, and finally switches back to the release page to end the command. A single command should carry no more than 64 written and 64 read bytes. While a byte is shifting, the host interface stalls.

Top module: `ispi_bridge`

## Requirements
- R1: After reset, chip select is high, SCK is low, the host interface is ready, all four address bytes read back as 0x00, and the read-data output is 0x00.
- R2: Register offsets 0, 1, 2 and 3 hold address bits 7:0, 15:8, 23:16 and 31:24. Each offset reads back its own byte. A byte keeps its value until that same offset is written again.
- R3: A data-port write (offset 4) with address bits 31:12 all ones and bits 15:8 equal to 0xFE drives chip select high, whatever the data value is. It produces no SCK pulse and completes without stalling.
- R4: A data-port write with address bits 31:12 all ones and bits 15:8 equal to 0xFD drives chip select low. It shifts the written byte out on MOSI, most significant bit first, in SPI mode 0, using exactly 8 SCK pulses. Chip select stays low for the whole shift.
- R5: A data-port read at the 0xFD page drives chip select low and makes exactly 8 SCK pulses. It returns the 8 MISO bits, sampled on rising SCK edges and taken most significant bit first. During the read, MOSI is held high.
- R6: A data-port access that starts a byte shift holds the ready output low for exactly 16×SCK_HALF clock cycles after the accepting edge. Strobes presented while ready is low are ignored.
- R7: A data-port access whose address lies outside the window, or that reads the 0xFE page, or that touches any page other than 0xFE and 0xFD, leaves chip select unchanged. It produces no SCK pulse, does not stall, and reads as 0xFF.
- R8: SCK idles low. Each SCK pulse is SCK_HALF clock cycles high and SCK_HALF clock cycles low, so consecutive rising edges are 2×SCK_HALF cycles apart.
- R9: Writes to offsets 5, 6 and 7 change nothing, and reads from those offsets return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_off | input | 3 | Register offset: 0 to 3 are address bytes, 4 is the data port |
| host_wr | input | 1 | Write strobe; accepted on a rising edge while host_ready is high; wins over host_rd |
| host_rd | input | 1 | Read strobe; accepted on a rising edge while host_ready is high |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data; valid once host_ready is high again after a read |
| host_ready | output | 1 | Low while a byte shift is in progress |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A corrupted address byte shows up at the ports on the very next data-port access. That access either lands on the wrong page or leaves the window, so the bench sees a missing or extra group of eight SCK pulses, or a 0xFF where a flash byte was expected. A wrong bit or phase counter in the shifter shows up within one byte time. It appears as a pulse count other than eight, an edge spacing other than 2×SCK_HALF, a stall length other than 16×SCK_HALF, or a byte misaligned by one bit position. A chip-select register left in the wrong state is seen on the access that should have changed it.

// File: rtl/ispi_pkg.sv
package ispi_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 4;
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int OFF_W      = 3;
    localparam int SEL_W      = $clog2(ADDR_BYTES);

    localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(ADDR_BYTES);

    // Window: address bits 31:12 all ones; bits 15:8 pick the function
    localparam int               TAG_LSB   = 12;
    localparam logic [ADDR_W-1:TAG_LSB] WIN_TAG = '1;
    localparam logic [BYTE_W-1:0] PG_RELEASE = 8'hFE;
    localparam logic [BYTE_W-1:0] PG_SHIFT   = 8'hFD;
    localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'hFF;

    typedef enum logic [1:0] {
        PK_NONE    = 2'd0,
        PK_RELEASE = 2'd1,
        PK_SHIFT   = 2'd2
    } page_kind_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [OFF_W-1:0]   off;
        logic [BYTE_W-1:0]  wdata;
    } host_req_t;

    function automatic page_kind_e classify(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:TAG_LSB] != WIN_TAG) return PK_NONE;
        if (a[15:8] == PG_RELEASE)          return PK_RELEASE;
        if (a[15:8] == PG_SHIFT)            return PK_SHIFT;
        return PK_NONE;
    endfunction

endpackage

// File: rtl/ispi_addr_regs.sv
module ispi_addr_regs
    import ispi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [ADDR_W-1:0]     addr
);

    generate
        for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
            logic [BYTE_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= '0;
                else if (we && sel == SEL_W'(b))
                    byte_q <= wdata;
            end
            assign addr[b*BYTE_W +: BYTE_W] = byte_q;
        end
    endgenerate

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(addr)); // R2

endmodule

// File: rtl/ispi_page_decode.sv
module ispi_page_decode
    import ispi_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output page_kind_e        kind
);

    always_comb kind = classify(addr);

endmodule

// File: rtl/ispi_shifter.sv
module ispi_shifter
    import ispi_pkg::*;
#(
    parameter int SCK_HALF = 2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BYTE_W-1:0]  tx,
    input  logic               miso,
    output logic               busy,
    output logic               fin,
    output logic               sck,
    output logic               mosi,
    output logic [BYTE_W-1:0]  rx
);

    localparam int CW  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int BCW = $clog2(BYTE_W);

    logic [CW-1:0]     cnt;
    logic [BCW-1:0]    bitn;
    logic [BYTE_W-1:0] sreg, rreg;
    logic              sck_q, busy_q;
    logic              phase_end;

    assign phase_end = (cnt == CW'(SCK_HALF - 1));
    assign fin       = busy_q && phase_end && sck_q && (bitn == BCW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            sreg   <= '0;
            rreg   <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            sreg   <= tx;
        end else if (busy_q) begin
            if (phase_end) begin
                cnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rreg  <= {rreg[BYTE_W-2:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (fin) begin
                        busy_q <= 1'b0;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sreg <= {sreg[BYTE_W-2:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign sck  = sck_q;
    assign mosi = sreg[BYTE_W-1];
    assign rx   = rreg;

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sck_q); // R8

    AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_q) |-> $stable(mosi)); // R4

endmodule

// File: rtl/ispi_bridge.sv
module ispi_bridge
    import ispi_pkg::*;
#(
    parameter int SCK_HALF = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        host_off,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_ready,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    host_req_t         req;
    logic [ADDR_W-1:0] addr;
    page_kind_e        kind;
    logic              accept, is_reg, is_data, do_wr, do_rd, start;
    logic              sh_busy, sh_fin;
    logic [BYTE_W-1:0] sh_rx, tx_byte, reg_byte;
    logic              cs_n_q, rd_pend;
    logic [BYTE_W-1:0] rdata_q;

    always_comb begin
        req.wr    = host_wr;
        req.rd    = host_rd;
        req.off   = host_off;
        req.wdata = host_wdata;
    end

    assign host_ready = !sh_busy;
    assign accept     = (req.wr || req.rd) && host_ready;
    assign do_wr      = req.wr;
    assign do_rd      = req.rd && !req.wr;
    assign is_reg     = (req.off < OFF_DATA);
    assign is_data    = (req.off == OFF_DATA);
    assign start      = accept && is_data && (kind == PK_SHIFT);
    assign tx_byte    = do_wr ? req.wdata : IDLE_BYTE;
    assign reg_byte   = addr[req.off[SEL_W-1:0]*BYTE_W +: BYTE_W];

    ispi_addr_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (accept && do_wr && is_reg),
        .sel   (req.off[SEL_W-1:0]),
        .wdata (req.wdata),
        .addr  (addr)
    );

    ispi_page_decode u_dec (
        .addr (addr),
        .kind (kind)
    );

    ispi_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tx    (tx_byte),
        .miso  (spi_miso),
        .busy  (sh_busy),
        .fin   (sh_fin),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .rx    (sh_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q  <= 1'b1;
            rd_pend <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept && do_wr && is_data && kind == PK_RELEASE)
                cs_n_q <= 1'b1;
            if (start) begin
                cs_n_q  <= 1'b0;
                rd_pend <= do_rd;
            end
            if (accept && do_rd) begin
                if (is_reg)
                    rdata_q <= reg_byte;
                else if (!start)
                    rdata_q <= IDLE_BYTE;
            end
            if (sh_fin && rd_pend)
                rdata_q <= sh_rx;
        end
    end

    assign spi_cs_n   = cs_n_q;
    assign host_rdata = rdata_q;

    AST_CS_LOW_WHILE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> !spi_cs_n); // R4

    AST_RELEASE_RAISES_CS: assert property (@(posedge clk) disable iff (rst)
        (accept && do_wr && is_data && kind == PK_RELEASE) |=> spi_cs_n); // R3

    AST_NOHIT_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (accept && is_data && kind != PK_SHIFT) |=> !sh_busy); // R7

    AST_STALL_BLOCKS_REGS: assert property (@(posedge clk) disable iff (rst)
        sh_busy |=> $stable(addr)); // R6

endmodule

// File: tb/ispi_bridge_test.sv
module ispi_bridge_test;

    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_off = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready, spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, sck_rises = 0, first_rise = 0, last_rise = 0;
    int sl_idx = 0;
    logic [7:0] sl_byte = 8'h00, mosi_cap = 8'h00;

    always #2 clk = ~clk;

    ispi_bridge #(.SCK_HALF(H)) uut (
        .clk(clk), .rst(rst), .host_off(host_off), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Flash model: mode 0, MSB first
    assign spi_miso = sl_byte[3'd7 - 3'(sl_idx)];

    always @(posedge clk) cyc++;

    always @(posedge spi_sck) begin
        if (sl_idx == 0) first_rise = cyc;
        last_rise = cyc;
        mosi_cap  = {mosi_cap[6:0], spi_mosi};
        sl_idx++;
        sck_rises++;
    end

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: act=%0d exp=<150000", cyc);
        finish_up();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [2:0] off, input logic [7:0] d,
                          output logic [7:0] q, output int stall);
        @(negedge clk);
        sl_idx = 0;
        host_wr = w; host_rd = !w; host_off = off; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        stall = 0;
        while (!host_ready) begin
            stall++;
            @(negedge clk);
        end
        q = host_rdata;
    endtask

    task automatic set_addr(input logic [31:0] a);
        logic [7:0] q; int s;
        for (int b = 0; b < 4; b++) access(1'b1, 3'(b), a[b*8 +: 8], q, s);
    endtask

    initial begin
        logic [7:0] q; int s; int r0;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        chk(host_ready == 1'b1, "R1 ready", host_ready, 1);
        chk(host_rdata == 8'h00, "R1 rdata", host_rdata, 0);
        for (int b = 0; b < 4; b++) begin
            access(1'b0, 3'(b), 8'h00, q, s);
            chk(q == 8'h00, "R1 addr byte", q, 0);
        end

        // R2 little-endian address bytes, read back
        for (int i = 0; i < 16; i++) begin
            a = 32'h9E3779B9 * (i + 1);
            set_addr(a);
            for (int b = 0; b < 4; b++) begin
                access(1'b0, 3'(b), 8'h00, q, s);
                chk(q == a[b*8 +: 8] && s == 0, "R2 readback", q, a[b*8 +: 8]);
            end
        end

        // R9 offsets 5..7 ignored, read 0xFF
        set_addr(32'hA1B2C3D4);
        for (int o = 5; o < 8; o++) begin
            access(1'b1, 3'(o), 8'h00, q, s);
            access(1'b0, 3'(o), 8'h00, q, s);
            chk(q == 8'hFF, "R9 read", q, 8'hFF);
        end
        for (int b = 0; b < 4; b++) begin
            access(1'b0, 3'(b), 8'h00, q, s);
            chk(q == 8'(32'hA1B2C3D4 >> (8*b)), "R9 addr kept", q, 8'(32'hA1B2C3D4 >> (8*b)));
        end

        // R4/R6/R8 write sweep at the shift page
        set_addr(32'hFFFFFD00);
        for (int v = 0; v < 256; v++) begin
            r0 = sck_rises;
            access(1'b1, 3'd4, 8'(v), q, s);
            chk(mosi_cap == 8'(v), "R4 mosi byte", mosi_cap, v);
            chk(sck_rises - r0 == 8, "R4 pulse count", sck_rises - r0, 8);
            chk(spi_cs_n == 1'b0 && spi_sck == 1'b0, "R4 cs low after", spi_cs_n, 0);
            chk(s == 16*H, "R6 stall length", s, 16*H);
            chk(last_rise - first_rise == 7*2*H, "R8 sck spacing", last_rise - first_rise, 7*2*H);
        end

        // R3 release page: rewrite only byte 1, any value, cs high
        for (int v = 0; v < 256; v += 51) begin
            access(1'b1, 3'd1, 8'hFE, q, s);
            r0 = sck_rises;
            access(1'b1, 3'd4, 8'(v), q, s);
            chk(spi_cs_n == 1'b1, "R3 cs high", spi_cs_n, 1);
            chk(sck_rises == r0 && s == 0, "R3 no sck/stall", sck_rises - r0, 0);
            access(1'b1, 3'd1, 8'hFD, q, s);
            access(1'b1, 3'd4, 8'h5A, q, s);
            chk(spi_cs_n == 1'b0, "R3 reselect low", spi_cs_n, 0);
        end

        // R5 read sweep
        for (int v = 0; v < 256; v++) begin
            sl_byte = 8'(v ^ 8'h3C);
            r0 = sck_rises;
            access(1'b0, 3'd4, 8'h00, q, s);
            chk(q == 8'(v ^ 8'h3C), "R5 read byte", q, v ^ 8'h3C);
            chk(sck_rises - r0 == 8 && mosi_cap == 8'hFF, "R5 pulses/mosi", mosi_cap, 8'hFF);
            chk(spi_cs_n == 1'b0, "R5 cs low", spi_cs_n, 0);
        end

        // R6 strobes during stall ignored
        @(negedge clk);
        sl_idx = 0;
        host_wr = 1'b1; host_off = 3'd4; host_wdata = 8'hC3;
        @(negedge clk);
        host_off = 3'd1; host_wdata = 8'h55;
        repeat (4) @(negedge clk);
        host_wr = 1'b0;
        while (!host_ready) @(negedge clk);
        access(1'b0, 3'd1, 8'h00, q, s);
        chk(q == 8'hFD, "R6 stalled strobe ignored", q, 8'hFD);
        chk(mosi_cap == 8'hC3, "R6 byte intact", mosi_cap, 8'hC3);

        // R7 out-of-window / other pages (cs currently low)
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: a = 32'hFFFFFC00;
                1: a = 32'hFFFEFD00;
                2: a = 32'h7FFFFD00;
                3: a = 32'hFFFF0D00;
                default: a = 32'hFFFFFE00;
            endcase
            set_addr(a);
            r0 = sck_rises;
            if (k != 4) access(1'b1, 3'd4, 8'h00, q, s);
            access(1'b0, 3'd4, 8'h00, q, s);
            chk(q == 8'hFF && s == 0, "R7 read 0xFF", q, 8'hFF);
            chk(sck_rises == r0, "R7 no sck", sck_rises - r0, 0);
            chk(spi_cs_n == 1'b0, "R7 cs unchanged", spi_cs_n, 0);
        end

        finish_up();
    end

endmodule